// File: doc/BRIEF.md
# Disk-Change Status Latch

This block keeps the single disk-change status bit that a floppy-style drive controller reports to the host. The bit is set when the controller comes out of reset, and again whenever media is inserted or ejected. It stays set through any number of host reads. It is cleared only when the head physically steps to a different track while media is in the drive. A seek whose target cylinder equals the present cylinder produces no step, so it cannot clear the bit.

The seek logic presents a seek strobe together with the target and present cylinder numbers. The block derives the step pulse from these and exposes it. The host read path captures the flag into a read byte, which carries the flag at a fixed bit position and zeros everywhere else. The drive supplies a media-present level and single-cycle insert and eject strobes.

Top module: `media_change_latch`

## Requirements
- R1: After reset, `chg_flag` is 1 and `rd_data` is 0x00.
- R2: On a cycle with `rd_en` high, `rd_data` takes on the flag value from before that edge at bit `FLAG_BIT` (default 7, so a set flag reads as 0x80), with every other bit 0. While `rd_en` is low, `rd_data` holds its value.
- R3: Host reads (`rd_en`) never change `chg_flag`.
- R4: While `media_present` is 0, step pulses leave `chg_flag` unchanged.
- R5: A seek strobe whose target cylinder equals the present cylinder produces no step pulse and leaves `chg_flag` unchanged.
- R6: A step pulse on a clock edge where `media_present` is 1 and no insert or eject strobe is active clears `chg_flag` from the next cycle on.
- R7: An `insert_evt` or `eject_evt` strobe sets `chg_flag` on the next cycle. This takes priority over a step pulse in the same cycle.
- R8: Once cleared, `chg_flag` stays 0 until an insert or eject strobe arrives.
- R9: `step_out` is high combinationally in exactly the cycles where `seek_go` is high and `tgt_cyl` differs from `cur_cyl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| media_present | input | 1 | Level: media is in the drive |
| insert_evt | input | 1 | Single-cycle media insertion strobe |
| eject_evt | input | 1 | Single-cycle media ejection strobe |
| seek_go | input | 1 | Seek logic issues a head positioning request this cycle |
| tgt_cyl | input | CYL_W | Target cylinder of the request |
| cur_cyl | input | CYL_W | Present cylinder of the head |
| rd_en | input | 1 | Host read of the status byte |
| step_out | output | 1 | Step pulse derived from the request |
| chg_flag | output | 1 | Latched disk-change flag |
| rd_data | output | DATA_W | Captured status byte, flag at FLAG_BIT |

## Verification
The latch is exercised with repeated reads and with stepping seeks while the drive is empty, which show that neither reads nor steps clear the flag without media. An insert followed by a same-cylinder seek and then a different-cylinder seek separates a mere request from a real step. Collisions of an eject or insert strobe with a step in one cycle confirm that setting wins. The media-present level is changed on the same edge as a step to show that the latch samples it at that edge.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

   typedef enum logic [1:0] {
      FLAG_HOLD  = 2'd0,
      FLAG_SET   = 2'd1,
      FLAG_CLEAR = 2'd2
   } flag_action_e;

   function automatic flag_action_e pick_action(input logic set_req,
                                                input logic clr_req);
      if (set_req)      return FLAG_SET;
      else if (clr_req) return FLAG_CLEAR;
      else              return FLAG_HOLD;
   endfunction

endpackage

// File: rtl/mcl_step_gen.sv
module mcl_step_gen #(
   parameter int CYL_W = 8
) (
   input  logic             seek_go,
   input  logic [CYL_W-1:0] tgt_cyl,
   input  logic [CYL_W-1:0] cur_cyl,
   output logic             step
);
   logic moves;

   generate
      if (CYL_W < 1) begin : g_bad_width
         $error("mcl_step_gen: CYL_W must be at least 1");
      end
   endgenerate

   always_comb begin
      moves = (tgt_cyl != cur_cyl);
      step  = seek_go & moves;
   end
endmodule

// File: rtl/mcl_flag_core.sv
module mcl_flag_core
   import mcl_pkg::*;
#(
   parameter bit RESET_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic insert_evt,
   input  logic eject_evt,
   input  logic step,
   input  logic media_present,
   output logic flag
);
   flag_action_e action;
   logic         set_req;
   logic         clr_req;

   always_comb begin
      set_req = insert_evt | eject_evt;
      clr_req = step & media_present;
      action  = pick_action(set_req, clr_req);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= RESET_VALUE;
      end else begin
         case (action)
            FLAG_SET:   flag <= 1'b1;
            FLAG_CLEAR: flag <= 1'b0;
            default:    flag <= flag;
         endcase
      end
   end
endmodule

// File: rtl/mcl_read_port.sv
module mcl_read_port #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              flag,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] shaped;

   generate
      if (FLAG_BIT >= DATA_W || FLAG_BIT < 0) begin : g_bad_pos
         $error("mcl_read_port: FLAG_BIT outside the data word");
      end
      for (genvar i = 0; i < DATA_W; i++) begin : g_bits
         if (i == FLAG_BIT) begin : g_flag
            assign shaped[i] = flag;
         end else begin : g_zero
            assign shaped[i] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= shaped;
   end
endmodule

// File: rtl/media_change_latch.sv
module media_change_latch #(
   parameter int CYL_W    = 8,
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              media_present,
   input  logic              insert_evt,
   input  logic              eject_evt,
   input  logic              seek_go,
   input  logic [CYL_W-1:0]  tgt_cyl,
   input  logic [CYL_W-1:0]  cur_cyl,
   input  logic              rd_en,
   output logic              step_out,
   output logic              chg_flag,
   output logic [DATA_W-1:0] rd_data
);
   logic step_w;
   logic flag_w;

   mcl_step_gen #(.CYL_W(CYL_W)) u_step (
      .seek_go (seek_go),
      .tgt_cyl (tgt_cyl),
      .cur_cyl (cur_cyl),
      .step    (step_w)
   );

   mcl_flag_core #(.RESET_VALUE(1'b1)) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .insert_evt    (insert_evt),
      .eject_evt     (eject_evt),
      .step          (step_w),
      .media_present (media_present),
      .flag          (flag_w)
   );

   mcl_read_port #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .flag    (flag_w),
      .rd_data (rd_data)
   );

   assign step_out = step_w;
   assign chg_flag = flag_w;
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              media_present,
   input logic              insert_evt,
   input logic              eject_evt,
   input logic              rd_en,
   input logic              step_out,
   input logic              chg_flag,
   input logic [DATA_W-1:0] rd_data
);
   logic events;
   assign events = insert_evt | eject_evt;

   p_set_on_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      events |=> chg_flag);

   p_clear_on_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_out && media_present && !events) |=> !chg_flag);

   p_empty_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag && !media_present) |=> chg_flag);

   p_no_step_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag && !step_out) |=> chg_flag);

   p_clear_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg_flag && !events) |=> !chg_flag);

   p_read_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_data == ($past(chg_flag) ? (DATA_W'(1) << FLAG_BIT) : '0)));

   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   p_one_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_data));
endmodule

bind media_change_latch mcl_checker #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .media_present (media_present),
   .insert_evt    (insert_evt),
   .eject_evt     (eject_evt),
   .rd_en         (rd_en),
   .step_out      (step_out),
   .chg_flag      (chg_flag),
   .rd_data       (rd_data)
);

// File: tb/media_change_latch_bench.sv
module media_change_latch_bench;
   localparam int CW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          media_present = 1'b0;
   logic          insert_evt = 1'b0;
   logic          eject_evt = 1'b0;
   logic          seek_go = 1'b0;
   logic [CW-1:0] tgt_cyl = '0;
   logic [CW-1:0] cur_cyl = '0;
   logic          rd_en = 1'b0;
   logic          step_out;
   logic          chg_flag;
   logic [DW-1:0] rd_data;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   int m_flag = 1;
   int m_rd = 0;

   always #5 clk = ~clk;

   media_change_latch u_media_change_latch (
      .clk(clk), .rst_n(rst_n), .media_present(media_present),
      .insert_evt(insert_evt), .eject_evt(eject_evt), .seek_go(seek_go),
      .tgt_cyl(tgt_cyl), .cur_cyl(cur_cyl), .rd_en(rd_en),
      .step_out(step_out), .chg_flag(chg_flag), .rd_data(rd_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at negedge, check step, model the edge, check state.
   task automatic cyc(input bit med, input bit ins, input bit ej, input bit sg,
                      input int tg, input int cu, input bit rd,
                      input string tag_step, input string tag_flag);
      int exp_step;
      media_present = med; insert_evt = ins; eject_evt = ej;
      seek_go = sg; tgt_cyl = CW'(tg); cur_cyl = CW'(cu); rd_en = rd;
      #1;
      exp_step = (sg && tg != cu) ? 1 : 0;
      check({tag_step, " step_out"}, int'(step_out), exp_step);
      @(posedge clk);
      if (rd) m_rd = m_flag ? 'h80 : 0;
      if (ins || ej) m_flag = 1;
      else if (exp_step == 1 && med) m_flag = 0;
      @(negedge clk);
      check({tag_flag, " chg_flag"}, int'(chg_flag), m_flag);
      check({tag_flag, " rd_data"}, int'(rd_data), m_rd);
   endtask

   initial begin
      #200000;
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 chg_flag", int'(chg_flag), 1);
      check("R1 rd_data", int'(rd_data), 0);
      // R2/R3: repeated reads with empty drive
      for (int i = 0; i < 3; i++) cyc(0,0,0,0,0,0,1, "R9", "R3");
      cyc(0,0,0,0,0,0,0, "R9", "R2");
      // R4: stepping seeks with no media
      cyc(0,0,0,1,1,0,0, "R9", "R4");
      cyc(0,0,0,1,0,1,1, "R9", "R4");
      cyc(0,0,0,1,5,5,0, "R5", "R4");
      // R7: insertion keeps the flag set
      cyc(1,1,0,0,0,0,0, "R9", "R7");
      cyc(1,0,0,0,0,0,1, "R9", "R2");
      // R5: seek to the present cylinder
      cyc(1,0,0,1,0,0,1, "R5", "R5");
      cyc(1,0,0,1,9,9,0, "R5", "R5");
      // R6: real step clears
      cyc(1,0,0,1,1,0,0, "R9", "R6");
      cyc(1,0,0,0,0,0,1, "R9", "R2");
      // R8: stays clear through reads, steps, seeks
      for (int i = 0; i < 3; i++) cyc(1,0,0,i[0],i+2,1,1, "R9", "R8");
      cyc(0,0,0,1,3,4,0, "R9", "R8");
      // R7: eject collides with a step
      cyc(1,0,1,1,2,1,1, "R9", "R7");
      cyc(0,0,0,0,0,0,1, "R9", "R2");
      // R4: empty drive after eject, steps keep it set
      cyc(0,0,0,1,0,1,0, "R9", "R4");
      cyc(0,0,0,1,7,0,1, "R9", "R4");
      // R6 with level sampled at edge: insert, then step while media appears
      cyc(0,1,0,0,0,0,0, "R9", "R7");
      cyc(1,0,0,1,4,3,0, "R9", "R6");
      // R7: insert collides with step
      cyc(1,1,0,1,3,4,1, "R9", "R7");
      cyc(1,0,0,1,3,4,1, "R9", "R6");
      cyc(1,0,0,0,0,0,1, "R9", "R2");
      // R1: reset mid-run restores set flag and zero byte
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_flag = 1; m_rd = 0;
      check("R1 chg_flag", int'(chg_flag), 1);
      check("R1 rd_data", int'(rd_data), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule